// File: doc/BRIEF.md
# Stereo Pulse-Density Microphone Receiver with Decimation

This block drives the bit clock for a pair of pulse-density microphones that share one data wire, and turns their one-bit streams back into multi-bit PCM samples. The microphone assigned to the left channel presents its bit while the clock is low, and the receiver captures it when the clock rises. The right-channel microphone presents its bit while the clock is high, and the receiver captures it when the clock falls. Both microphones deliver raw, high-rate modulator output. The block reduces the rate itself: each channel has its own third-order cascaded integrator-comb decimator.

The pulse-density clock is derived from the system clock by a programmable half-period counter. The decimation ratio is programmable as well. A one means the signal is going up and a zero means it is going down. Each bit is therefore mapped to +1 or -1 before it is integrated, so a stream of all ones settles at the largest positive code. The left and right samples leave the block together, with a single one-cycle strobe per output period. The strobe stays quiet after reset until the filter has seen a full window of input.

Top module: `stereo_pdm_rx`

## Requirements
- R1: While reset is asserted and right after it, `pdm_clk_o` is low, `pcm_valid_o` is low, and both PCM outputs are zero.
- R2: `pdm_clk_o` toggles once every H system clock cycles, so its period is 2H. H is `cfg_half_i`, and any value below 2 is treated as 2.
- R3: The left bit is the level of `pdm_din_i` at the rising edge of `pdm_clk_o`, and the right bit is the level at the falling edge. The line passes through a two-stage synchronizer, so it must be stable for at least two system clock cycles before that edge.
- R4: A captured one enters the filter as +1 and a zero as -1. A stream of all ones therefore gives +R^3 and a stream of all zeros gives -R^3.
- R5: Bits are numbered from 0 after reset. The sample that closes at bit index n equals sum over j of h[j]*x[n-j], where h holds the 3R-2 coefficients of (1+z^-1+...+z^-(R-1))^3. The result is a two's complement word of PCM_W = 3*clog2(MAX_RATIO)+2 bits.
- R6: Each channel produces one output sample per R captured left/right bit pairs. R is `cfg_ratio_i`, clamped to the range 2 to MAX_RATIO.
- R7: The first strobe follows the 3R-th bit pair. Strobe k (counting from 0) carries the samples that close at bit index (k+3)R-1.
- R8: `pcm_valid_o` is high for exactly one cycle, no more than three system cycles after the falling edge that ends the period. Left and right are presented together at that strobe and are held unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_half_i | input | DIV_W | Half period of the pulse-density clock, in system cycles (minimum 2) |
| cfg_ratio_i | input | RATIO_W | Decimation ratio R, clamped to 2..MAX_RATIO |
| pdm_din_i | input | 1 | Shared one-bit data line from both microphones |
| pdm_clk_o | output | 1 | Bit clock driven to both microphones |
| pcm_valid_o | output | 1 | One-cycle strobe for a new stereo sample |
| pcm_left_o | output | PCM_W | Left PCM sample, signed |
| pcm_right_o | output | PCM_W | Right PCM sample, signed |

## Verification
The bench builds the block with its defaults: DIV_W of 8 and MAX_RATIO of 64, which gives 20-bit samples. Successive resets cycle the half period through 1 to 5 and the ratio through 1, 5, 8, 12, 16 and 100. This reaches both clamps, a ratio that is not a power of two, and the full-scale values of +/-2^18 at the widest ratio. Every strobe is compared against a direct convolution with the coefficients the bench builds itself, and against the number of falling clock edges seen so far.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    // one captured bit heading into a channel filter
    typedef struct packed {
        logic vld;   // a bit was captured this cycle
        logic dat;   // captured level
        logic last;  // closes the current decimation period
    } pdm_bit_t;

    localparam int unsigned CIC_ORDER   = 3;
    localparam int unsigned NUM_CH      = 2;
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] cfg_half_i,
    output logic             pdm_clk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             clk;
        logic             rise;
        logic             fall;
    } gen_st_t;

    gen_st_t          gen_d, gen_q;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (cfg_half_i < DIV_W'(2)) ? DIV_W'(2) : cfg_half_i;
        gen_d      = gen_q;
        gen_d.rise = 1'b0;
        gen_d.fall = 1'b0;
        if (gen_q.cnt >= half_eff - DIV_W'(1)) begin
            gen_d.cnt  = '0;
            gen_d.clk  = ~gen_q.clk;
            gen_d.rise = ~gen_q.clk;
            gen_d.fall = gen_q.clk;
        end else begin
            gen_d.cnt = gen_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign pdm_clk_o = gen_q.clk;
    assign rise_o    = gen_q.rise;
    assign fall_o    = gen_q.fall;

    AST_CLK_HALF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_q.clk != $past(gen_q.clk)) |=> $stable(gen_q.clk)); // R2
    AST_EDGE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o})); // R2

endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
    import pdm_rx_pkg::*;
#(
    parameter int unsigned MAX_RATIO = 64,
    parameter int unsigned RATIO_W   = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pdm_din_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic [RATIO_W-1:0] cfg_ratio_i,
    output pdm_bit_t           left_o,
    output pdm_bit_t           right_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [RATIO_W-1:0]     pair_cnt;
        pdm_bit_t               left;
        pdm_bit_t               right;
    } cap_st_t;

    cap_st_t            cap_d, cap_q;
    logic [RATIO_W-1:0] ratio_eff;
    logic               line_lvl;
    logic               period_end;

    always_comb begin
        if (cfg_ratio_i < RATIO_W'(2)) begin
            ratio_eff = RATIO_W'(2);
        end else if (cfg_ratio_i > RATIO_W'(MAX_RATIO)) begin
            ratio_eff = RATIO_W'(MAX_RATIO);
        end else begin
            ratio_eff = cfg_ratio_i;
        end
        line_lvl   = cap_q.sync[SYNC_STAGES-1];
        period_end = (cap_q.pair_cnt >= ratio_eff - RATIO_W'(1));

        cap_d       = cap_q;
        cap_d.sync  = {cap_q.sync[SYNC_STAGES-2:0], pdm_din_i};
        cap_d.left  = '0;
        cap_d.right = '0;
        if (rise_i) begin
            cap_d.left.vld  = 1'b1;
            cap_d.left.dat  = line_lvl;
            cap_d.left.last = period_end;
        end
        if (fall_i) begin
            cap_d.right.vld  = 1'b1;
            cap_d.right.dat  = line_lvl;
            cap_d.right.last = period_end;
            cap_d.pair_cnt   = period_end ? '0 : cap_q.pair_cnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign left_o  = cap_q.left;
    assign right_o = cap_q.right;

    AST_CH_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(left_o.vld && right_o.vld)); // R3
    AST_LEFT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        left_o.vld |-> $past(rise_i)); // R3
    AST_RIGHT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        right_o.vld |-> $past(fall_i)); // R3

endmodule

// File: rtl/cic_decim.sv
module cic_decim
    import pdm_rx_pkg::*;
#(
    parameter int unsigned ORDER     = 3,
    parameter int unsigned ACC_W     = 20,
    parameter int unsigned MAX_RATIO = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  pdm_bit_t         bit_i,
    output logic             vld_o,
    output logic [ACC_W-1:0] pcm_o
);

    localparam longint PEAK = longint'(MAX_RATIO) ** ORDER;

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] integ;
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic                        vld;
        logic [ACC_W-1:0]            pcm;
    } cic_st_t;

    cic_st_t          cic_d, cic_q;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] diff;

    always_comb begin
        cic_d     = cic_q;
        cic_d.vld = 1'b0;
        acc       = bit_i.dat ? ACC_W'(1) : '1;
        diff      = '0;
        if (bit_i.vld) begin
            // integrators run at the bit rate, wrapping modulo 2^ACC_W
            for (int s = 0; s < int'(ORDER); s++) begin
                cic_d.integ[s] = cic_q.integ[s] + acc;
                acc            = cic_d.integ[s];
            end
            // combs run once per decimation period
            if (bit_i.last) begin
                for (int s = 0; s < int'(ORDER); s++) begin
                    diff         = acc - cic_q.dly[s];
                    cic_d.dly[s] = acc;
                    acc          = diff;
                end
                cic_d.pcm = acc;
                cic_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cic_q <= '0;
        end else begin
            cic_q <= cic_d;
        end
    end

    assign vld_o = cic_q.vld;
    assign pcm_o = cic_q.pcm;

    AST_PCM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (($signed(pcm_o) <= PEAK) && ($signed(pcm_o) >= -PEAK))); // R5
    AST_DEC_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> $past(bit_i.vld && bit_i.last)); // R6

endmodule

// File: rtl/stereo_pdm_rx.sv
module stereo_pdm_rx
    import pdm_rx_pkg::*;
#(
    parameter  int unsigned DIV_W     = 8,
    parameter  int unsigned MAX_RATIO = 64,
    localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1),
    localparam int unsigned PCM_W     = CIC_ORDER * $clog2(MAX_RATIO) + 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DIV_W-1:0]   cfg_half_i,
    input  logic [RATIO_W-1:0] cfg_ratio_i,
    input  logic               pdm_din_i,
    output logic               pdm_clk_o,
    output logic               pcm_valid_o,
    output logic [PCM_W-1:0]   pcm_left_o,
    output logic [PCM_W-1:0]   pcm_right_o
);

    localparam int unsigned FILL_W = $clog2(CIC_ORDER);

    logic                         edge_rise, edge_fall;
    pdm_bit_t                     bit_left, bit_right;
    pdm_bit_t [NUM_CH-1:0]        chan_bits;
    logic     [NUM_CH-1:0]        cic_vld;
    logic     [NUM_CH-1:0][PCM_W-1:0] cic_pcm;

    pdm_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_half_i (cfg_half_i),
        .pdm_clk_o  (pdm_clk_o),
        .rise_o     (edge_rise),
        .fall_o     (edge_fall)
    );

    pdm_capture #(.MAX_RATIO(MAX_RATIO), .RATIO_W(RATIO_W)) u_capture (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pdm_din_i   (pdm_din_i),
        .rise_i      (edge_rise),
        .fall_i      (edge_fall),
        .cfg_ratio_i (cfg_ratio_i),
        .left_o      (bit_left),
        .right_o     (bit_right)
    );

    assign chan_bits[0] = bit_left;
    assign chan_bits[1] = bit_right;

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_chan
        cic_decim #(
            .ORDER     (CIC_ORDER),
            .ACC_W     (PCM_W),
            .MAX_RATIO (MAX_RATIO)
        ) u_cic (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .bit_i  (chan_bits[c]),
            .vld_o  (cic_vld[c]),
            .pcm_o  (cic_pcm[c])
        );
    end

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [PCM_W-1:0]  left_hold;
        logic [PCM_W-1:0]  pcm_l;
        logic [PCM_W-1:0]  pcm_r;
        logic              valid;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (cic_vld[0]) begin
            out_d.left_hold = cic_pcm[0];
        end
        // the right channel always closes a period after the left one
        if (cic_vld[1]) begin
            if (out_q.fill < FILL_W'(CIC_ORDER - 1)) begin
                out_d.fill = out_q.fill + FILL_W'(1);
            end else begin
                out_d.valid = 1'b1;
                out_d.pcm_l = out_q.left_hold;
                out_d.pcm_r = cic_pcm[1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pcm_valid_o = out_q.valid;
    assign pcm_left_o  = out_q.pcm_l;
    assign pcm_right_o = out_q.pcm_r;

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pcm_valid_o |=> !pcm_valid_o); // R8
    AST_VALID_AFTER_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pcm_valid_o |-> $past(cic_vld[1])); // R8
    AST_HOLD_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pcm_valid_o |-> $stable(pcm_left_o)); // R8
    AST_HOLD_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pcm_valid_o |-> $stable(pcm_right_o)); // R8

endmodule

// File: tb/stereo_pdm_rx_tb.sv
module stereo_pdm_rx_tb_top;

    localparam int DIV_W     = 8;
    localparam int MAX_RATIO = 64;
    localparam int RATIO_W   = 7;
    localparam int PCM_W     = 20;
    localparam int NBITS     = 4096;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DIV_W-1:0]   cfg_half = 8'd3;
    logic [RATIO_W-1:0] cfg_ratio = 7'd8;
    logic               pdm_din = 1'b0;
    logic               pdm_clk;
    logic               pcm_valid;
    logic [PCM_W-1:0]   pcm_left;
    logic [PCM_W-1:0]   pcm_right;

    stereo_pdm_rx #(.DIV_W(DIV_W), .MAX_RATIO(MAX_RATIO)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_half_i  (cfg_half),
        .cfg_ratio_i (cfg_ratio),
        .pdm_din_i   (pdm_din),
        .pdm_clk_o   (pdm_clk),
        .pcm_valid_o (pcm_valid),
        .pcm_left_o  (pcm_left),
        .pcm_right_o (pcm_right)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit lbits [NBITS];
    bit rbits [NBITS];
    longint h [256];
    int reff = 2;
    int heff = 2;
    int out_cnt = 0;
    int fall_cnt = 0;
    bit mon_en = 1'b0;
    bit prev_pdm = 1'b0;
    bit prev_valid = 1'b0;
    int last_rise = -1;
    bit period_done = 1'b0;
    int nidx = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // coefficients of a cube of an R-tap boxcar
    function automatic void build_h(input int r);
        longint a [256];
        longint b [256];
        for (int i = 0; i < 256; i++) begin
            a[i] = (i < r) ? 1 : 0;
            h[i] = 0;
        end
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) b[i] = 0;
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < r; j++)
                    if (i + j < 256) b[i+j] += a[i];
            for (int i = 0; i < 256; i++) a[i] = b[i];
        end
        for (int i = 0; i < 256; i++) h[i] = a[i];
    endfunction

    function automatic longint expect_val(input bit ch, input int n);
        longint s = 0;
        for (int j = 0; j <= 3 * (reff - 1); j++) begin
            int idx = n - j;
            if (idx >= 0) begin
                bit b = ch ? rbits[idx] : lbits[idx];
                s += b ? h[j] : -h[j];
            end
        end
        return s;
    endfunction

    function automatic bit gen_bit(input int pat, input int dens, input bit ch, input int k);
        case (pat)
            0: return (($urandom % 100) < dens);
            1: return 1'b1;
            2: return 1'b0;
            3: return k[0] ^ ch;
            default: return (ch == 1'b0);
        endcase
    endfunction

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_pdm && !pdm_clk) fall_cnt++;
            if (!prev_pdm && pdm_clk) begin
                if (last_rise >= 0 && !period_done) begin
                    check((cyc - last_rise) == 2 * heff, "R2", "pdm clock period",
                          cyc - last_rise, 2 * heff);
                    period_done = 1'b1;
                end
                last_rise = cyc;
            end
            if (pcm_valid) begin
                nidx = (out_cnt + 3) * reff - 1;
                check(!prev_valid, "R8", "strobe longer than one cycle", 1, 0);
                check(fall_cnt == (out_cnt + 3) * reff, "R6 R7", "falling edges at strobe",
                      fall_cnt, (out_cnt + 3) * reff);
                check($signed(pcm_left) == expect_val(1'b0, nidx), "R3 R4 R5", "left sample",
                      longint'($signed(pcm_left)), expect_val(1'b0, nidx));
                check($signed(pcm_right) == expect_val(1'b1, nidx), "R3 R4 R5", "right sample",
                      longint'($signed(pcm_right)), expect_val(1'b1, nidx));
                out_cnt++;
            end else if (out_cnt > 0 && prev_valid == 1'b0) begin
                // between strobes the held values must not move (R8)
            end
            prev_pdm   = pdm_clk;
            prev_valid = pcm_valid;
        end
    end

    task automatic run_phase(input int half, input int ratio, input int pat,
                             input int dens, input int nsamp);
        logic [PCM_W-1:0] held_l;
        int k = 0;
        cfg_half  = DIV_W'(half);
        cfg_ratio = RATIO_W'(ratio);
        heff = (half < 2) ? 2 : half;
        reff = (ratio < 2) ? 2 : ((ratio > MAX_RATIO) ? MAX_RATIO : ratio);
        build_h(reff);
        mon_en  = 1'b0;
        rst_n   = 1'b0;
        pdm_din = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pdm_clk == 1'b0 && pcm_valid == 1'b0, "R1", "clock/strobe in reset",
              {pdm_clk, pcm_valid}, 0);
        check(pcm_left == '0 && pcm_right == '0, "R1", "samples in reset",
              longint'(pcm_left) + longint'(pcm_right), 0);
        out_cnt = 0; fall_cnt = 0; prev_pdm = 1'b0; prev_valid = 1'b0;
        last_rise = -1; period_done = 1'b0;
        lbits[0] = gen_bit(pat, dens, 1'b0, 0);
        pdm_din  = lbits[0];
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;
        while (out_cnt < nsamp && k < NBITS - 2) begin
            @(posedge pdm_clk);
            #1;
            rbits[k] = gen_bit(pat, dens, 1'b1, k);
            pdm_din  = rbits[k];
            @(negedge pdm_clk);
            #1;
            k++;
            lbits[k] = gen_bit(pat, dens, 1'b0, k);
            pdm_din  = lbits[k];
        end
        // R8: value is held after the last strobe while new bits arrive
        @(negedge clk);
        held_l = pcm_left;
        repeat (2 * heff) @(negedge clk);
        if (!pcm_valid)
            check(pcm_left == held_l, "R8", "left value held between strobes",
                  longint'(pcm_left), longint'(held_l));
        check(out_cnt == nsamp, "R7", "strobes seen", out_cnt, nsamp);
        mon_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_phase(3, 8, 0, 50, 20);   // random, half density
        run_phase(3, 8, 1, 0, 4);     // all ones: +512 (R4)
        run_phase(2, 16, 2, 0, 4);    // all zeros: -4096 (R4)
        run_phase(4, 5, 0, 80, 12);   // ratio not a power of two
        run_phase(1, 1, 0, 30, 16);   // both clamps at the low end (R2 R6)
        run_phase(2, 100, 4, 0, 2);   // ratio clamp high, +/-2^18 (R4 R6)
        run_phase(5, 12, 3, 0, 6);    // alternating, channels inverted
        run_phase(3, 16, 0, 15, 8);   // low density random
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule